// File: doc/BRIEF.md
# SPI Command Frame Decoder

This block sits on the slave side of an SPI link, behind a byte-wide shift register. It takes one byte per `byte_valid` pulse while chip select is asserted. The first byte is an opcode, and the opcode decides how many field bytes follow. The block collects those bytes most significant first and, when CRC protection is on, checks a trailing CRC7 byte. It then reports the command on a parallel output together with a one-cycle strobe. A frame that fails the CRC check raises `crc_error`. An unknown opcode raises `opcode_error`.

Each frame ends in one of three ways: a strobe, a CRC error or an opcode error. At that moment the block also produces the two bytes the slave sends back: an echo of the opcode and a status byte. The block handles one frame per chip-select assertion. Bytes that follow a finished frame are ignored until chip select drops. This leaves the bus free for responses and data packets, which other logic handles.

The control path is a four-state machine:
- `ST_IDLE` waits for an opcode. A legal opcode moves it to `ST_FIELDS`; an illegal one moves it to `ST_HOLD`.
- `ST_FIELDS` counts the field bytes down. After the last one it moves to `ST_CHECK` when CRC is on, or to `ST_HOLD` when CRC is off.
- `ST_CHECK` takes the CRC byte and then moves to `ST_HOLD`.
- `ST_HOLD` ignores all bytes.

From any state, chip select going inactive returns the machine to `ST_IDLE`.

Top module: `spicmd_frame_decoder`

## Requirements
- R1: After reset, `cmd_valid`, `crc_error`, `opcode_error` and `rsp_valid` are low, and `rsp_echo`, `rsp_state` and all command fields are zero.
- R2: Legal opcodes and their field byte counts (the CRC byte not included):
  - C1/C2: 5
  - C3: 6
  - C4: 3
  - C5, C6: 3
  - C7/C8: 6
  - C9: 7
  - CA: 3
  - CF: 3

  `cmd_valid` pulses for exactly one cycle, starting in the cycle after the final byte of the frame is accepted, and `cmd_opcode` carries the opcode.
- R3: Fields are taken most significant byte first:
  - C9 and CA: a 24-bit address in field bytes 1..3; C9 also carries 32 data bits in bytes 4..7.
  - C1/C2: a 24-bit address, then a 16-bit size, zero-extended on `cmd_size`.
  - C7/C8: a 24-bit address, then a 24-bit size.

  Fields a command does not carry are output as zero, and so is the address for C5, C6 and CF.
- R4: For C3 and C4, bit 7 of the first field byte appears on `cmd_clockless` and is cleared from the 16-bit address. C3 carries 32 data bits after its address. The pad byte of C4 is ignored.
- R5: With CRC on, a CRC7 is run over the opcode and the field bytes:
  - polynomial x^7+x^3+1, register preset to 0x7F, bits processed MSB first;
  - the result is compared with bits 7:1 of the final byte, and bit 0 of that byte is ignored;
  - on a mismatch, `crc_error` pulses for one cycle and `cmd_valid` stays low.
- R6: With CRC off, the frame has no CRC byte. `crc_enable` is sampled together with the opcode byte, and later changes within the frame have no effect.
- R7: An opcode outside the legal set pulses `opcode_error` once. The remaining bytes until chip select drops produce no further strobe.
- R8: Each frame outcome pulses `rsp_valid` and updates `rsp_echo` with the opcode byte. It also sets `rsp_state` as follows: 0x00 for success, 0x01 for a CRC mismatch, 0x02 for an illegal opcode. Both bytes hold their value until the next outcome.
- R9: Chip select going inactive in mid-frame aborts the frame with no strobe and no response update. The next assertion of chip select starts a fresh frame.
- R10: Bytes received after a completed frame, while chip select remains asserted, produce no strobe and leave the response bytes unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_active | input | 1 | Chip select asserted (active high) |
| byte_valid | input | 1 | A received byte is present on `byte_data` this cycle |
| byte_data | input | 8 | Received byte |
| crc_enable | input | 1 | CRC byte present and checked; sampled with the opcode |
| cmd_valid | output | 1 | One-cycle strobe for a decoded command |
| cmd_opcode | output | 8 | Decoded opcode |
| cmd_addr | output | 24 | Decoded address |
| cmd_size | output | 24 | Decoded transfer size |
| cmd_wdata | output | 32 | Decoded write data |
| cmd_clockless | output | 1 | Clockless-access flag of internal commands |
| crc_error | output | 1 | One-cycle strobe on CRC mismatch |
| opcode_error | output | 1 | One-cycle strobe on illegal opcode |
| rsp_valid | output | 1 | Response bytes updated this cycle |
| rsp_echo | output | 8 | First response byte: opcode echo |
| rsp_state | output | 8 | Second response byte: status |

## Verification
The hardest situations to reach are those where the frame length and the CRC decision interact: a frame whose opcode was latched with CRC on while `crc_enable` has since changed, and a CRC byte that differs from the expected one only in bit 0 or only in bit 1. The bench builds each frame byte by byte with its own bit-serial CRC. It then corrupts chosen bits of the CRC byte and toggles `crc_enable` right after the opcode. It also drops chip select part-way through a frame and keeps it asserted past the end of another frame, then checks that strobes and response bytes appear only where the requirements allow.

// File: rtl/spicmd_pkg.sv
package spicmd_pkg;

    localparam int ADDR_W      = 24;
    localparam int SIZE_W      = 24;
    localparam int DATA_W      = 32;
    localparam int CRC_W       = 7;
    localparam int MAX_FIELDS  = 7;
    localparam int CNT_W       = $clog2(MAX_FIELDS + 1);
    localparam int SHIFT_W     = MAX_FIELDS * 8;

    localparam logic [CRC_W-1:0] CRC_POLY   = 7'h09;
    localparam logic [CRC_W-1:0] CRC_PRESET = 7'h7F;

    localparam logic [7:0] OP_DMA_WR     = 8'hC1;
    localparam logic [7:0] OP_DMA_RD     = 8'hC2;
    localparam logic [7:0] OP_INT_WR     = 8'hC3;
    localparam logic [7:0] OP_INT_RD     = 8'hC4;
    localparam logic [7:0] OP_TERM       = 8'hC5;
    localparam logic [7:0] OP_REPEAT     = 8'hC6;
    localparam logic [7:0] OP_XDMA_WR    = 8'hC7;
    localparam logic [7:0] OP_XDMA_RD    = 8'hC8;
    localparam logic [7:0] OP_WORD_WR    = 8'hC9;
    localparam logic [7:0] OP_WORD_RD    = 8'hCA;
    localparam logic [7:0] OP_RESET      = 8'hCF;

    localparam logic [7:0] RSP_OK        = 8'h00;
    localparam logic [7:0] RSP_CRC_BAD   = 8'h01;
    localparam logic [7:0] RSP_OP_BAD    = 8'h02;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_FIELDS,
        ST_CHECK,
        ST_HOLD
    } dec_state_e;

    // One byte through the CRC7 register, MSB first.
    function automatic logic [CRC_W-1:0] crc7_step(input logic [CRC_W-1:0] cur,
                                                   input logic [7:0] b);
        logic [CRC_W-1:0] r;
        logic             fb;
        r = cur;
        for (int i = 7; i >= 0; i--) begin
            fb = r[CRC_W-1] ^ b[i];
            r  = {r[CRC_W-2:0], 1'b0} ^ (fb ? CRC_POLY : '0);
        end
        return r;
    endfunction

endpackage

// File: rtl/spicmd_len_decode.sv
module spicmd_len_decode
    import spicmd_pkg::*;
(
    input  logic [7:0]       opcode,
    output logic             legal,
    output logic [CNT_W-1:0] field_bytes
);
    always_comb begin
        legal       = 1'b1;
        field_bytes = '0;
        unique case (opcode)
            OP_DMA_WR, OP_DMA_RD:                     field_bytes = CNT_W'(5);
            OP_INT_WR, OP_XDMA_WR, OP_XDMA_RD:        field_bytes = CNT_W'(6);
            OP_INT_RD, OP_TERM, OP_REPEAT,
            OP_WORD_RD, OP_RESET:                     field_bytes = CNT_W'(3);
            OP_WORD_WR:                               field_bytes = CNT_W'(7);
            default:                                  legal       = 1'b0;
        endcase
    end
endmodule

// File: rtl/spicmd_crc7.sv
module spicmd_crc7
    import spicmd_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             update,
    input  logic [7:0]       din,
    output logic [CRC_W-1:0] crc
);
    logic [CRC_W-1:0] crc_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      crc_q <= CRC_PRESET;
        else if (start)  crc_q <= crc7_step(CRC_PRESET, din);
        else if (update) crc_q <= crc7_step(crc_q, din);
    end

    assign crc = crc_q;
endmodule

// File: rtl/spicmd_field_shift.sv
module spicmd_field_shift #(
    parameter int BYTES = 7
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clear,
    input  logic               shift,
    input  logic [7:0]         din,
    output logic [BYTES*8-1:0] q,
    output logic [BYTES*8-1:0] d
);
    logic [BYTES*8-1:0] q_r;

    // Byte lanes: lane 0 takes the newest byte, each other lane takes its neighbour.
    for (genvar g = 0; g < BYTES; g++) begin : g_lane
        if (g == 0) begin : g_first
            assign d[7:0] = clear ? 8'h00 : (shift ? din : q_r[7:0]);
        end else begin : g_rest
            assign d[g*8 +: 8] = clear ? 8'h00 : (shift ? q_r[(g-1)*8 +: 8] : q_r[g*8 +: 8]);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q_r <= '0;
        else        q_r <= d;
    end

    assign q = q_r;
endmodule

// File: rtl/spicmd_frame_decoder.sv
module spicmd_frame_decoder
    import spicmd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_active,
    input  logic              byte_valid,
    input  logic [7:0]        byte_data,
    input  logic              crc_enable,
    output logic              cmd_valid,
    output logic [7:0]        cmd_opcode,
    output logic [ADDR_W-1:0] cmd_addr,
    output logic [SIZE_W-1:0] cmd_size,
    output logic [DATA_W-1:0] cmd_wdata,
    output logic              cmd_clockless,
    output logic              crc_error,
    output logic              opcode_error,
    output logic              rsp_valid,
    output logic [7:0]        rsp_echo,
    output logic [7:0]        rsp_state
);
    dec_state_e        state_q, state_d;
    logic [7:0]        op_q;
    logic              crc_on_q;
    logic [CNT_W-1:0]  remain_q;

    logic              take;
    logic              op_legal;
    logic [CNT_W-1:0]  op_fields;
    logic [CRC_W-1:0]  crc_val;
    logic [SHIFT_W-1:0] sh_q, sh_d;
    logic              last_field;
    logic              crc_match;

    logic              ev_done, ev_crc_bad, ev_op_bad;
    logic [ADDR_W-1:0] dec_addr;
    logic [SIZE_W-1:0] dec_size;
    logic [DATA_W-1:0] dec_wdata;
    logic              dec_clkl;

    assign take       = cs_active && byte_valid;
    assign last_field = (remain_q == CNT_W'(1));
    assign crc_match  = (byte_data[7:1] == crc_val);

    spicmd_len_decode u_len (
        .opcode      (byte_data),
        .legal       (op_legal),
        .field_bytes (op_fields)
    );

    spicmd_crc7 u_crc (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (state_q == ST_IDLE   && take),
        .update (state_q == ST_FIELDS && take),
        .din    (byte_data),
        .crc    (crc_val)
    );

    spicmd_field_shift #(.BYTES(MAX_FIELDS)) u_shift (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (state_q == ST_IDLE   && take),
        .shift (state_q == ST_FIELDS && take),
        .din   (byte_data),
        .q     (sh_q),
        .d     (sh_d)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next state and frame events
    always_comb begin
        state_d    = state_q;
        ev_done    = 1'b0;
        ev_crc_bad = 1'b0;
        ev_op_bad  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (take) begin
                    if (op_legal) begin
                        state_d = ST_FIELDS;
                    end else begin
                        state_d   = ST_HOLD;
                        ev_op_bad = 1'b1;
                    end
                end
            end
            ST_FIELDS: begin
                if (take && last_field) begin
                    if (crc_on_q) begin
                        state_d = ST_CHECK;
                    end else begin
                        state_d = ST_HOLD;
                        ev_done = 1'b1;
                    end
                end
            end
            ST_CHECK: begin
                if (take) begin
                    state_d    = ST_HOLD;
                    ev_done    = crc_match;
                    ev_crc_bad = !crc_match;
                end
            end
            ST_HOLD: begin
                state_d = ST_HOLD;
            end
            default: state_d = ST_IDLE;
        endcase
        if (!cs_active) state_d = ST_IDLE;
    end

    // Frame context: opcode, CRC mode and remaining field count
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q     <= '0;
            crc_on_q <= 1'b0;
            remain_q <= '0;
        end else if (state_q == ST_IDLE && take) begin
            op_q     <= byte_data;
            crc_on_q <= crc_enable;
            remain_q <= op_fields;
        end else if (state_q == ST_FIELDS && take) begin
            remain_q <= remain_q - CNT_W'(1);
        end
    end

    // Field extraction from the collected bytes (newest byte in the low lane)
    always_comb begin
        dec_addr  = '0;
        dec_size  = '0;
        dec_wdata = '0;
        dec_clkl  = 1'b0;
        unique case (op_q)
            OP_WORD_WR: begin
                dec_addr  = ADDR_W'(sh_d[55:32]);
                dec_wdata = DATA_W'(sh_d[31:0]);
            end
            OP_WORD_RD: begin
                dec_addr  = ADDR_W'(sh_d[23:0]);
            end
            OP_INT_WR: begin
                dec_clkl  = sh_d[47];
                dec_addr  = ADDR_W'(sh_d[46:32]);
                dec_wdata = DATA_W'(sh_d[31:0]);
            end
            OP_INT_RD: begin
                dec_clkl  = sh_d[23];
                dec_addr  = ADDR_W'(sh_d[22:8]);
            end
            OP_DMA_WR, OP_DMA_RD: begin
                dec_addr  = ADDR_W'(sh_d[39:16]);
                dec_size  = SIZE_W'(sh_d[15:0]);
            end
            OP_XDMA_WR, OP_XDMA_RD: begin
                dec_addr  = ADDR_W'(sh_d[47:24]);
                dec_size  = SIZE_W'(sh_d[23:0]);
            end
            default: begin
                dec_addr  = '0;
            end
        endcase
    end

    // Output registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_valid     <= 1'b0;
            cmd_opcode    <= '0;
            cmd_addr      <= '0;
            cmd_size      <= '0;
            cmd_wdata     <= '0;
            cmd_clockless <= 1'b0;
            crc_error     <= 1'b0;
            opcode_error  <= 1'b0;
            rsp_valid     <= 1'b0;
            rsp_echo      <= '0;
            rsp_state     <= '0;
        end else begin
            cmd_valid    <= ev_done;
            crc_error    <= ev_crc_bad;
            opcode_error <= ev_op_bad;
            rsp_valid    <= ev_done || ev_crc_bad || ev_op_bad;
            if (ev_done) begin
                cmd_opcode    <= op_q;
                cmd_addr      <= dec_addr;
                cmd_size      <= dec_size;
                cmd_wdata     <= dec_wdata;
                cmd_clockless <= dec_clkl;
                rsp_echo      <= op_q;
                rsp_state     <= RSP_OK;
            end else if (ev_crc_bad) begin
                rsp_echo      <= op_q;
                rsp_state     <= RSP_CRC_BAD;
            end else if (ev_op_bad) begin
                rsp_echo      <= byte_data;
                rsp_state     <= RSP_OP_BAD;
            end
        end
    end

endmodule

// File: rtl/spicmd_frame_decoder_chk.sv
module spicmd_frame_decoder_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cs_active,
    input logic       cmd_valid,
    input logic [7:0] cmd_opcode,
    input logic       cmd_clockless,
    input logic       crc_error,
    input logic       opcode_error,
    input logic       rsp_valid,
    input logic [7:0] rsp_echo,
    input logic [7:0] rsp_state
);
    // R2
    cmd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |=> !cmd_valid);

    // R5
    crc_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cmd_valid, crc_error, opcode_error}));

    // R8
    rsp_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> (rsp_state == 8'h00 && rsp_echo == cmd_opcode));

    // R8
    rsp_crc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        crc_error |-> rsp_state == 8'h01);

    // R8
    rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> ($stable(rsp_echo) && $stable(rsp_state)));

    // R4
    clockless_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_clockless) |-> (cmd_opcode == 8'hC3 || cmd_opcode == 8'hC4));

    // R9
    cs_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_active |=> !(cmd_valid || crc_error || opcode_error));
endmodule

bind spicmd_frame_decoder spicmd_frame_decoder_chk chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .cs_active     (cs_active),
    .cmd_valid     (cmd_valid),
    .cmd_opcode    (cmd_opcode),
    .cmd_clockless (cmd_clockless),
    .crc_error     (crc_error),
    .opcode_error  (opcode_error),
    .rsp_valid     (rsp_valid),
    .rsp_echo      (rsp_echo),
    .rsp_state     (rsp_state)
);

// File: tb/spicmd_frame_decoder_tb.sv
module spicmd_frame_decoder_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 200000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_active = 1'b0;
    logic        byte_valid = 1'b0;
    logic [7:0]  byte_data = 8'h00;
    logic        crc_enable = 1'b0;
    logic        cmd_valid;
    logic [7:0]  cmd_opcode;
    logic [23:0] cmd_addr;
    logic [23:0] cmd_size;
    logic [31:0] cmd_wdata;
    logic        cmd_clockless;
    logic        crc_error;
    logic        opcode_error;
    logic        rsp_valid;
    logic [7:0]  rsp_echo;
    logic [7:0]  rsp_state;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    int n_cmd = 0, n_crc = 0, n_op = 0, n_rsp = 0;
    logic [7:0]  fb [0:8];
    int          nb;

    always #(CLK_PERIOD/2) clk = ~clk;

    spicmd_frame_decoder dut_i (
        .clk(clk), .rst_n(rst_n), .cs_active(cs_active), .byte_valid(byte_valid),
        .byte_data(byte_data), .crc_enable(crc_enable), .cmd_valid(cmd_valid),
        .cmd_opcode(cmd_opcode), .cmd_addr(cmd_addr), .cmd_size(cmd_size),
        .cmd_wdata(cmd_wdata), .cmd_clockless(cmd_clockless), .crc_error(crc_error),
        .opcode_error(opcode_error), .rsp_valid(rsp_valid), .rsp_echo(rsp_echo),
        .rsp_state(rsp_state)
    );

    // Strobe counters, sampled away from the active edge
    always @(negedge clk) begin
        if (cmd_valid)    n_cmd++;
        if (crc_error)    n_crc++;
        if (opcode_error) n_op++;
        if (rsp_valid)    n_rsp++;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=%0d expected<=%0d cycles", cycles, WATCHDOG);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input logic [63:0] act,
                         input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [6:0] ref_crc(input int n);
        logic [6:0] c;
        logic       top;
        c = 7'h7F;
        for (int k = 0; k < n; k++) begin
            for (int i = 7; i >= 0; i--) begin
                top = c[6] ^ fb[k][i];
                c   = {c[5:0], 1'b0};
                if (top) c = c ^ 7'b0001001;
            end
        end
        return c;
    endfunction

    task automatic send_byte(input logic [7:0] b);
        @(negedge clk);
        byte_data  = b;
        byte_valid = 1'b1;
        @(negedge clk);
        byte_valid = 1'b0;
        @(negedge clk);
    endtask

    // Sends fb[0..nb-1] plus a CRC byte XOR corrupt when crc_on; flip toggles
    // crc_enable after the opcode byte; extra trailing bytes in the same select.
    task automatic run_frame(input bit crc_on, input logic [7:0] corrupt,
                             input bit flip, input int extra);
        @(negedge clk);
        cs_active  = 1'b1;
        crc_enable = crc_on;
        for (int k = 0; k < nb; k++) begin
            send_byte(fb[k]);
            if (flip && k == 0) crc_enable = ~crc_on;
        end
        if (crc_on) send_byte({ref_crc(nb), 1'b0} ^ corrupt);
        for (int k = 0; k < extra; k++) send_byte(8'hC9);
        repeat (2) @(negedge clk);
        cs_active = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic t_reset;
        check(!cmd_valid && !crc_error && !opcode_error && !rsp_valid, "R1 strobes", 
              {cmd_valid, crc_error, opcode_error, rsp_valid}, 0);
        check(rsp_echo == 0 && rsp_state == 0 && cmd_addr == 0 && cmd_wdata == 0,
              "R1 values", {rsp_echo, rsp_state, cmd_addr}, 0);
    endtask

    task automatic t_word_write;
        int c0 = n_cmd;
        fb[0]=8'hC9; fb[1]=8'h12; fb[2]=8'h34; fb[3]=8'h56;
        fb[4]=8'hDE; fb[5]=8'hAD; fb[6]=8'hBE; fb[7]=8'hEF; nb = 8;
        run_frame(1'b1, 8'h00, 1'b0, 0);
        check(n_cmd - c0 == 1, "R2 single strobe", n_cmd - c0, 1);
        check(cmd_opcode == 8'hC9 && cmd_addr == 24'h123456, "R3 word addr",
              {cmd_opcode, cmd_addr}, {8'hC9, 24'h123456});
        check(cmd_wdata == 32'hDEADBEEF && cmd_size == 0, "R3 word data", cmd_wdata, 32'hDEADBEEF);
        check(rsp_echo == 8'hC9 && rsp_state == 8'h00, "R8 ok response",
              {rsp_echo, rsp_state}, 16'hC900);
    endtask

    task automatic t_internal_write;
        fb[0]=8'hC3; fb[1]=8'h92; fb[2]=8'h34; fb[3]=8'h01;
        fb[4]=8'h02; fb[5]=8'h03; fb[6]=8'h04; nb = 7;
        run_frame(1'b1, 8'h00, 1'b0, 0);
        check(cmd_clockless == 1'b1 && cmd_addr == 24'h001234, "R4 clockless write",
              {cmd_clockless, cmd_addr}, {1'b1, 24'h001234});
        check(cmd_wdata == 32'h01020304, "R4 internal data", cmd_wdata, 32'h01020304);
    endtask

    task automatic t_internal_read;
        fb[0]=8'hC4; fb[1]=8'h00; fb[2]=8'hFF; fb[3]=8'h5A; nb = 4;
        run_frame(1'b1, 8'h00, 1'b0, 0);
        check(cmd_opcode == 8'hC4 && cmd_addr == 24'h0000FF && !cmd_clockless,
              "R4 internal read pad ignored", {cmd_clockless, cmd_addr}, 24'h0000FF);
    endtask

    task automatic t_ext_dma_nocrc;
        int c0 = n_cmd;
        fb[0]=8'hC7; fb[1]=8'hAB; fb[2]=8'hCD; fb[3]=8'hEF;
        fb[4]=8'h01; fb[5]=8'h23; fb[6]=8'h45; nb = 7;
        run_frame(1'b0, 8'h00, 1'b0, 0);
        check(n_cmd - c0 == 1, "R6 no crc byte strobe", n_cmd - c0, 1);
        check(cmd_addr == 24'hABCDEF && cmd_size == 24'h012345, "R3 ext dma fields",
              {cmd_addr, cmd_size}, {24'hABCDEF, 24'h012345});
    endtask

    task automatic t_dma;
        fb[0]=8'hC1; fb[1]=8'h00; fb[2]=8'h10; fb[3]=8'h20;
        fb[4]=8'h04; fb[5]=8'h00; nb = 6;
        run_frame(1'b1, 8'h00, 1'b0, 0);
        check(cmd_opcode == 8'hC1 && cmd_addr == 24'h001020 && cmd_size == 24'h000400,
              "R3 dma fields", {cmd_addr, cmd_size}, {24'h001020, 24'h000400});
    endtask

    task automatic t_reset_cmd;
        fb[0]=8'hCF; fb[1]=8'hFF; fb[2]=8'hFF; fb[3]=8'hFF; nb = 4;
        run_frame(1'b1, 8'h00, 1'b0, 0);
        check(cmd_opcode == 8'hCF && cmd_addr == 0, "R2 reset opcode",
              {cmd_opcode, cmd_addr}, {8'hCF, 24'h0});
    endtask

    task automatic t_crc_bad;
        int c0 = n_cmd, e0 = n_crc;
        fb[0]=8'hCA; fb[1]=8'h01; fb[2]=8'h02; fb[3]=8'h03; nb = 4;
        run_frame(1'b1, 8'h02, 1'b0, 0);
        check(n_crc - e0 == 1 && n_cmd == c0, "R5 crc mismatch", {n_crc - e0, n_cmd - c0}, 64'h1_0000_0000);
        check(rsp_echo == 8'hCA && rsp_state == 8'h01, "R8 crc response",
              {rsp_echo, rsp_state}, 16'hCA01);
    endtask

    task automatic t_crc_bit0;
        int c0 = n_cmd;
        fb[0]=8'hCA; fb[1]=8'h01; fb[2]=8'h02; fb[3]=8'h03; nb = 4;
        run_frame(1'b1, 8'h01, 1'b0, 0);
        check(n_cmd - c0 == 1 && cmd_addr == 24'h010203, "R5 crc bit0 ignored",
              cmd_addr, 24'h010203);
    endtask

    task automatic t_bad_opcode;
        int c0 = n_cmd, o0 = n_op, r0 = n_rsp;
        fb[0]=8'hC0; fb[1]=8'hC9; fb[2]=8'h00; fb[3]=8'h00; nb = 4;
        run_frame(1'b0, 8'h00, 1'b0, 0);
        check(n_op - o0 == 1 && n_cmd == c0, "R7 opcode error once",
              {n_op - o0, n_cmd - c0}, 64'h1_0000_0000);
        check(n_rsp - r0 == 1 && rsp_echo == 8'hC0 && rsp_state == 8'h02, "R7 R8 opcode response",
              {rsp_echo, rsp_state}, 16'hC002);
    endtask

    task automatic t_abort;
        int c0 = n_cmd, r0 = n_rsp;
        @(negedge clk);
        cs_active = 1'b1; crc_enable = 1'b1;
        send_byte(8'hC9); send_byte(8'h11); send_byte(8'h22);
        cs_active = 1'b0;
        repeat (3) @(negedge clk);
        check(n_cmd == c0 && n_rsp == r0 && rsp_state == 8'h02, "R9 abort no strobe",
              {n_cmd - c0, n_rsp - r0}, 0);
        fb[0]=8'hCA; fb[1]=8'h0A; fb[2]=8'h0B; fb[3]=8'h0C; nb = 4;
        run_frame(1'b1, 8'h00, 1'b0, 0);
        check(n_cmd - c0 == 1 && cmd_addr == 24'h0A0B0C, "R9 fresh frame after abort",
              cmd_addr, 24'h0A0B0C);
    endtask

    task automatic t_trailing;
        int c0 = n_cmd, r0 = n_rsp;
        fb[0]=8'hCA; fb[1]=8'h77; fb[2]=8'h88; fb[3]=8'h99; nb = 4;
        run_frame(1'b1, 8'h00, 1'b0, 9);
        check(n_cmd - c0 == 1 && n_rsp - r0 == 1, "R10 trailing bytes ignored",
              {n_cmd - c0, n_rsp - r0}, 64'h1_0000_0001);
        check(cmd_addr == 24'h778899 && rsp_echo == 8'hCA, "R10 fields kept", cmd_addr, 24'h778899);
    endtask

    task automatic t_enable_flip;
        int c0 = n_cmd, e0 = n_crc;
        fb[0]=8'hCA; fb[1]=8'h31; fb[2]=8'h32; fb[3]=8'h33; nb = 4;
        run_frame(1'b0, 8'h00, 1'b1, 0);
        check(n_cmd - c0 == 1 && n_crc == e0 && cmd_addr == 24'h313233,
              "R6 enable latched off", cmd_addr, 24'h313233);
        c0 = n_cmd;
        run_frame(1'b1, 8'h00, 1'b1, 0);
        check(n_cmd - c0 == 1 && n_crc == e0, "R6 enable latched on", n_cmd - c0, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset();
        t_word_write();
        t_internal_write();
        t_internal_read();
        t_ext_dma_nocrc();
        t_dma();
        t_reset_cmd();
        t_crc_bad();
        t_crc_bit0();
        t_bad_opcode();
        t_abort();
        t_trailing();
        t_enable_flip();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule